// File: doc/BRIEF.md
# Serial Channel Baud Tick Generator

This block produces the two timing strobes that one asynchronous serial channel needs: a sampling strobe and a bit-rate strobe. Both are single-cycle enables in the system clock domain. The block holds a writable control byte. From its fields the block builds a divider chain that runs from the system clock. The chain has a fixed prescaler of 10 or 30, then a power-of-two speed divider, then a sampling divider of 16 or 64. A speed code can instead select an external data clock. That clock is synchronized, and each of its rising edges becomes one sampling strobe.

The block also serves the channel's flow control. Clear-to-send can be read live through the control byte, and while it is high the transmit-empty flag passed on to the rest of the channel is forced low. The parity-sense bit is stored and exported but plays no part in timing.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the control byte reads back bits [6:0] = 7'b0000111. Bit 6 is the 64x-ratio bit, bit 5 is the odd-parity bit, bits 4:3 are unused and always read 0, and bits 2:0 are the speed code. Written values of bits 6, 5 and 2:0 read back unchanged.
- R2: Bit 7 of a write selects the prescaler. With the bit at 0 and speed code 0, a sampling strobe occurs every 10 system cycles. With the bit at 1, it occurs every 30 cycles.
- R3: Speed codes 0 to 6 multiply the sampling period by 2 to the power of the code, so the period is prescale × 2^code system cycles.
- R4: Bit 6 = 0 gives one bit strobe per 16 sampling strobes, and bit 6 = 1 gives one per 64. A bit strobe always falls in a cycle that also carries a sampling strobe.
- R5: Output parity_odd equals the stored bit 5 (0 = even, 1 = odd) and has no effect on either strobe.
- R6: Speed code 7 selects the external clock. The input passes through two synchronizing flops and a rising-edge detector. The sampling strobe is high for one cycle, in the cycle after the second system clock edge that samples the input high following a low.
- R7: No strobe is issued in a cycle that carries a write. Every divider restarts from zero at the write, so the first sampling strobe after a write with internal period T comes T cycles after the write edge, in the T-th cycle.
- R8: tx_empty_out equals tx_empty_in while cts_in is low, and it is 0 while cts_in is high.
- R9: Read bit 7 always shows the current level of cts_in, whatever prescale value was written and also during and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte read data |
| ext_clk_in | input | 1 | External data clock, asynchronous |
| cts_in | input | 1 | Clear-to-send level |
| tx_empty_in | input | 1 | Transmit-empty flag from the channel |
| tx_empty_out | output | 1 | Transmit-empty flag gated by clear-to-send |
| sample_tick | output | 1 | Sampling-rate strobe |
| bit_tick | output | 1 | Bit-rate strobe |
| parity_odd | output | 1 | Parity sense, 1 selects odd |

## Verification
The assertions check four things on every cycle. A bit strobe only appears together with a sampling strobe. Writes are silent and zero the prescaler. Edge strobes never come twice in a row. Clear-to-send always blocks the empty flag. The exact periods for each combination of prescale, speed code and ratio can only be shown by the bench's scenarios, and the same holds for the synchronizer latency of the external clock and the full-length first period after a write. The bench runs a cycle model of these rules over directed settings and random rate changes.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int CTL_W       = 8;
  localparam int SPEED_W     = 3;
  localparam int PRE_LO      = 10;
  localparam int PRE_HI      = 30;
  localparam int RATIO_LO    = 16;
  localparam int RATIO_HI    = 64;
  localparam int MAX_EXP     = 6;
  localparam int SYNC_STAGES = 2;
  localparam logic [SPEED_W-1:0] EXT_CODE = 3'd7;

  localparam int BIT_PRE   = 7;
  localparam int BIT_RATIO = 6;
  localparam int BIT_PAR   = 5;

  typedef struct packed {
    logic               pre_hi;
    logic               ratio_hi;
    logic               par_odd;
    logic [SPEED_W-1:0] speed;
  } ctl_t;
endpackage

// File: rtl/bt_prescaler.sv
module bt_prescaler #(
  parameter int DIV_LO = 10,
  parameter int DIV_HI = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic sel_hi,
  output logic tick
);
  localparam int CW = $clog2(DIV_HI);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last;

  always_comb begin
    last  = sel_hi ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
    tick  = !restart && (cnt_q == last);
    cnt_d = cnt_q;
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r7_prescale_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
  a_r2_prescale_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DIV_HI - 1));
endmodule

// File: rtl/bt_pow2_div.sv
module bt_pow2_div #(
  parameter int MAX_EXP = 6,
  parameter int EXP_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             in_tick,
  input  logic [EXP_W-1:0] expo,
  output logic             out_tick
);
  logic [MAX_EXP-1:0] cnt_q, cnt_d;
  logic [MAX_EXP-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < MAX_EXP; i++) begin
      if (i < int'(expo)) mask[i] = 1'b1;
    end
    out_tick = in_tick && (cnt_q == mask);
    cnt_d    = cnt_q;
    if (restart)       cnt_d = '0;
    else if (out_tick) cnt_d = '0;
    else if (in_tick)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r3_speed_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q & ~mask) == '0);
endmodule

// File: rtl/bt_ext_edge.sv
module bt_ext_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] pipe_q;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[0] <= 1'b0;
          else        pipe_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[g] <= 1'b0;
          else        pipe_q[g] <= pipe_q[g-1];
        end
      end
    end
  endgenerate

  assign rise = pipe_q[STAGES-1] && !pipe_q[STAGES];

  a_r6_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/bt_ratio_div.sv
module bt_ratio_div #(
  parameter int N_LO = 16,
  parameter int N_HI = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic sel_hi,
  input  logic in_tick,
  output logic out_tick
);
  localparam int CW = $clog2(N_HI);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last;

  always_comb begin
    last     = sel_hi ? CW'(N_HI - 1) : CW'(N_LO - 1);
    out_tick = in_tick && (cnt_q == last);
    cnt_d    = cnt_q;
    if (restart)       cnt_d = '0;
    else if (out_tick) cnt_d = '0;
    else if (in_tick)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r4_ratio_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             ext_clk_in,
  input  logic             cts_in,
  input  logic             tx_empty_in,
  output logic             tx_empty_out,
  output logic             sample_tick,
  output logic             bit_tick,
  output logic             parity_odd
);
  logic [1:0] rst_pipe_q;
  logic       rst_q;
  ctl_t       ctl_q, ctl_d;
  logic       wr_eff;
  logic       pre_tick, speed_tick, ext_rise, ext_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q  = rst_pipe_q[1];
  assign wr_eff = ctl_wr && rst_q;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_eff) begin
      ctl_d.pre_hi   = ctl_wdata[BIT_PRE];
      ctl_d.ratio_hi = ctl_wdata[BIT_RATIO];
      ctl_d.par_odd  = ctl_wdata[BIT_PAR];
      ctl_d.speed    = ctl_wdata[SPEED_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ctl_q.pre_hi   <= 1'b0;
      ctl_q.ratio_hi <= 1'b0;
      ctl_q.par_odd  <= 1'b0;
      ctl_q.speed    <= EXT_CODE;
    end else begin
      ctl_q <= ctl_d;
    end
  end

  bt_prescaler #(.DIV_LO(PRE_LO), .DIV_HI(PRE_HI)) u_pre (
    .clk(clk), .rst_n(rst_q), .restart(wr_eff),
    .sel_hi(ctl_q.pre_hi), .tick(pre_tick));

  bt_pow2_div #(.MAX_EXP(MAX_EXP), .EXP_W(SPEED_W)) u_speed (
    .clk(clk), .rst_n(rst_q), .restart(wr_eff), .in_tick(pre_tick),
    .expo(ctl_q.speed), .out_tick(speed_tick));

  bt_ext_edge #(.STAGES(SYNC_STAGES)) u_ext (
    .clk(clk), .rst_n(rst_q), .async_in(ext_clk_in), .rise(ext_rise));

  assign ext_mode    = (ctl_q.speed == EXT_CODE);
  assign sample_tick = !wr_eff && (ext_mode ? ext_rise : speed_tick);

  bt_ratio_div #(.N_LO(RATIO_LO), .N_HI(RATIO_HI)) u_ratio (
    .clk(clk), .rst_n(rst_q), .restart(wr_eff), .sel_hi(ctl_q.ratio_hi),
    .in_tick(sample_tick), .out_tick(bit_tick));

  assign parity_odd   = ctl_q.par_odd;
  assign tx_empty_out = tx_empty_in && !cts_in;
  assign ctl_rdata    = {cts_in, ctl_q.ratio_hi, ctl_q.par_odd, 2'b00, ctl_q.speed};

  a_r4_bit_on_sample: assert property (@(posedge clk) disable iff (!rst_q)
    bit_tick |-> sample_tick);
  a_r7_silent_write: assert property (@(posedge clk) disable iff (!rst_q)
    wr_eff |-> (!sample_tick && !bit_tick));
  a_r8_cts_blocks_empty: assert property (@(posedge clk) disable iff (!rst_q)
    cts_in |-> !tx_empty_out);
endmodule

// File: tb/baud_tick_gen_test.sv
`timescale 1ns/1ps
module baud_tick_gen_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, ctl_wr, ext_clk_in, cts_in, tx_empty_in;
  logic [7:0] ctl_wdata, ctl_rdata;
  logic tx_empty_out, sample_tick, bit_tick, parity_odd;

  baud_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .ext_clk_in(ext_clk_in), .cts_in(cts_in),
    .tx_empty_in(tx_empty_in), .tx_empty_out(tx_empty_out),
    .sample_tick(sample_tick), .bit_tick(bit_tick), .parity_odd(parity_odd));

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 0;

  bit       m_pre, m_r64, m_par;
  bit [2:0] m_spd;
  int       phase, ectr;
  bit       e1, e2, e3;
  bit       ext_lvl;

  always @(posedge clk) cycles++;

  task automatic check(input string req, input int act, input int expv);
    vectors++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic int pre_div(input bit hi);
    return hi ? 30 : 10;
  endfunction

  function automatic int ratio_n(input bit hi);
    return hi ? 64 : 16;
  endfunction

  task automatic cyc(input bit wr, input logic [7:0] d, input bit ext,
                     input bit cts, input bit te);
    int per, n;
    bit es, eb, edge_now;
    @(negedge clk);
    ctl_wr = wr; ctl_wdata = d; ext_clk_in = ext; cts_in = cts; tx_empty_in = te;
    #1;
    n = ratio_n(m_r64);
    edge_now = e2 && !e3;
    if (wr) begin
      es = 0; eb = 0;
    end else if (m_spd == 3'd7) begin
      es = edge_now;
      eb = edge_now && ((ectr % n) == n - 1);
    end else begin
      per = pre_div(m_pre) << m_spd;
      es = ((phase + 1) % per) == 0;
      eb = ((phase + 1) % (per * n)) == 0;
    end
    if (wr)                check("R7", sample_tick, 0);
    else if (m_spd == 3'd7) check("R6", sample_tick, es);
    else if (m_spd != 3'd0) check("R3", sample_tick, es);
    else                    check("R2", sample_tick, es);
    check("R4", bit_tick, eb);
    check("R8", tx_empty_out, te && !cts);
    check("R9", ctl_rdata[7], cts);
    check("R1", ctl_rdata[6:0], {m_r64, m_par, 2'b00, m_spd});
    check("R5", parity_odd, m_par);
    if (wr) begin
      m_pre = d[7]; m_r64 = d[6]; m_par = d[5]; m_spd = d[2:0];
      phase = 0; ectr = 0;
    end else begin
      phase++;
      if (m_spd == 3'd7 && edge_now) ectr++;
    end
    e3 = e2; e2 = e1; e1 = ext;
  endtask

  task automatic run(input int len, input int ext_half);
    for (int i = 0; i < len; i++) begin
      if (ext_half > 0 && (i % ext_half) == 0) ext_lvl = !ext_lvl;
      cyc(0, 8'h00, ext_lvl, ($urandom % 4) == 0, $urandom % 2);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    cyc(1, d, ext_lvl, 0, 1);
  endtask

  initial begin
    int seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst_n = 0; ctl_wr = 0; ctl_wdata = 0; ext_clk_in = 0; cts_in = 0; tx_empty_in = 0;
    ext_lvl = 0;
    m_pre = 0; m_r64 = 0; m_par = 0; m_spd = 3'd7;
    phase = 0; ectr = 0; e1 = 0; e2 = 0; e3 = 0;
    repeat (3) @(negedge clk);
    // R9: clear-to-send visible even in reset
    cts_in = 1; #1;
    check("R9", ctl_rdata[7], 1);
    cts_in = 0;
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    // R1: reset values
    check("R1", ctl_rdata, 8'b0000_0111);
    check("R5", parity_odd, 0);
    cts_in = 1; #1;
    check("R9", ctl_rdata[7], 1);
    cts_in = 0;

    // R2: prescale 10, code 0, ratio 16
    wr_ctl(8'b0000_0000); run(400, 0);
    // R2: prescale 30, code 0
    wr_ctl(8'b1000_0000); run(1000, 0);
    // R3: prescale 10, code 6
    wr_ctl(8'b0000_0110); run(2000, 0);
    // R4: ratio 64, prescale 10, code 0
    wr_ctl(8'b0100_0000); run(1400, 0);
    // R5: odd parity, unused bits set, timing unchanged
    wr_ctl(8'b0011_1001); run(500, 0);
    // R7: rewrite mid-period, then again back to back
    wr_ctl(8'b0000_0000); run(7, 0);
    wr_ctl(8'b0000_0000); wr_ctl(8'b0000_0001); run(300, 0);
    // R6: external clock, ratio 16 then 64
    ext_lvl = 0;
    wr_ctl(8'b0000_0111); run(600, 3);
    wr_ctl(8'b0100_0111); run(1800, 2);

    for (int s = 0; s < 25; s++) begin
      logic [7:0] d;
      int len, half;
      bit [2:0] spd;
      bit r64;
      spd = (($urandom % 5) == 0) ? 3'd7 : 3'($urandom % 4);
      r64 = (spd <= 3'd1 || spd == 3'd7) ? (($urandom % 4) == 0) : 1'b0;
      d = {1'($urandom), r64, 1'($urandom), 2'($urandom), spd};
      half = (spd == 3'd7) ? 1 + int'($urandom % 4) : int'($urandom % 5);
      len = (spd == 3'd7) ? 1500
            : (pre_div(d[7]) << spd) * ratio_n(r64) * 2 + 20;
      if (len > 4000) len = 4000;
      wr_ctl(d);
      run(len, half);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    wait (cycles >= 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule